// File: doc/BRIEF.md
# Watch Timer with Buzzer Tap

This block keeps time for a controller that can sleep. It forms a nominal 32.768 kHz working reference, called fW here, and counts it in a 14-bit divider. A sticky timekeeping flag is raised every 2^14 reference ticks, which is every half second. A fast test mode raises the flag every 2^7 ticks instead, so firmware can be stepped through quickly. Each time the flag is set, a one-cycle wake pulse goes to standby control.

The reference comes from one of two sources. One is the main system clock `clk` divided by a prescaler (128 by default). The other is a low-speed subsystem clock, which is already synchronised into the `clk` domain and arrives as the one-cycle strobe `sub_tick`. Bit 3 of the divider is a square wave at fW/16 (2.048 kHz). It is driven onto the buzzer pin only when the buzzer is enabled and the shared port bit is set as an output.

Firmware controls the block through an 8-bit mode write:

| Bit | Function |
|-----|----------|
| 0 | Source: 1 = subsystem strobe, 0 = prescaled main clock |
| 1 | Fast test mode |
| 2 | Run |
| 3 | One-shot divider clear |
| 7 | Buzzer enable |

Bits 4 to 6 are ignored. The flag is cleared by a write-one-to-clear strobe.

Top module: `watch_timer`

## Requirements
- R1: While reset is asserted, and until the first mode write, `tick_flag`, `wake` and `buz_pin` are all low.
- R2: With source = subsystem, normal mode and run = 1, `tick_flag` is set on the 16384th `sub_tick` edge after the edge that wrote run = 1. It is still clear after the 16383rd.
- R3: With fast mode (bit 1) set, the flag interval shrinks to 128 reference ticks.
- R4: With source = main (bit 0 = 0), one reference tick occurs every MAIN_DIV (128) clock cycles, counted from the start write. Fast mode therefore sets the flag 16384 clock edges after that write.
- R5: While run (bit 2) is 0, the divider holds at zero. No flag is raised and `buz_pin` stays low, whatever the other bits and `sub_tick` do.
- R6: A mode write with bit 3 set restarts the prescaler and divider from zero on that edge. The clear acts once only: later periods run at the full length.
- R7: `tick_flag` stays set until `flag_clr` is high at a clock edge. When a set and a clear fall on the same edge, the set wins.
- R8: `wake` is high for exactly one cycle, in the same cycle that a flag set first shows on `tick_flag`.
- R9: `buz_pin` equals divider bit 3 (fW/16, high for reference counts 8 to 15 mod 16) when buzzer enable (bit 7) is 1 and `buz_dir_out` is 1. Otherwise `buz_pin` is 0.
- R10: Mode bits 4 to 6 have no effect on flag timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | Synchronised subsystem clock strobe, one pulse per subsystem cycle |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| buz_dir_out | input | 1 | Shared port bit is configured as an output |
| tick_flag | output | 1 | Sticky timekeeping flag |
| wake | output | 1 | One-cycle standby release pulse |
| buz_pin | output | 1 | Gated buzzer output |

## Verification
The hardest case to reach from the ports is a flag clear that lands on exactly the edge where the divider wraps. A clear that lands one cycle early or late looks like correct behaviour. To hit it, the bench starts the fast subsystem mode with `sub_tick` held high, so every clock edge is one reference tick. It counts 127 edges from the start write and raises `flag_clr` just before the 128th. The same edge counting is used to place a mid-period divider clear, and to sample the buzzer tap on both sides of each 8-count boundary.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Bit positions inside the mode write word
  localparam int unsigned MODE_SRC_BIT  = 0;
  localparam int unsigned MODE_FAST_BIT = 1;
  localparam int unsigned MODE_RUN_BIT  = 2;
  localparam int unsigned MODE_CLR_BIT  = 3;
  localparam int unsigned MODE_BUZ_BIT  = 7;

  // Stored portion of the mode register (the clear bit is not stored)
  typedef struct packed {
    logic buz_en;
    logic run;
    logic fast;
    logic src_sub;
  } wt_mode_t;

endpackage

// File: rtl/wt_refsel.sv
module wt_refsel #(
  parameter int unsigned MAIN_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic src_sub,
  input  logic sub_tick,
  output logic ref_tick
);

  localparam int unsigned PRE_W = (MAIN_DIV > 1) ? $clog2(MAIN_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_W'(MAIN_DIV - 1));

  // Prescaler next state: held at zero while stopped or cleared
  always_comb begin
    pre_d = pre_q;
    if (!run || restart) begin
      pre_d = '0;
    end else if (pre_wrap) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // Source selection
  always_comb begin
    ref_tick = 1'b0;
    if (run && !restart) begin
      ref_tick = src_sub ? sub_tick : pre_wrap;
    end
  end

  generate
    if (MAIN_DIV > 1) begin : g_spacing_chk
      // R4: prescaled ticks are never back to back
      assert_main_tick_spaced_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ref_tick && !src_sub) |=> !(ref_tick && !src_sub)
      );
    end
  endgenerate

endmodule

// File: rtl/wt_divider.sv
module wt_divider #(
  parameter int unsigned DIV_W   = 14,
  parameter int unsigned FAST_W  = 7,
  parameter int unsigned BUZ_BIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic fast,
  input  logic ref_tick,
  output logic set_req,
  output logic buz_tap
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             full_wrap;
  logic             fast_wrap;

  assign full_wrap = &cnt_q;
  assign fast_wrap = &cnt_q[FAST_W-1:0];

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (ref_tick) begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Flag request on the tick that wraps the selected span
  assign set_req = ref_tick && (fast ? fast_wrap : full_wrap);
  assign buz_tap = cnt_q[BUZ_BIT];

  // R5: a stopped timer keeps the divider at zero
  assert_held_when_stopped_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)
  );

  // R6: a clear restarts counting from zero
  assert_restart_zero_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)
  );

  // R2: the divider only moves on reference ticks
  assert_no_step_without_tick_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (run && !restart && !ref_tick) |=> $stable(cnt_q)
  );

endmodule

// File: rtl/wt_flag.sv
module wt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag,
  output logic wake
);

  logic flag_q;
  logic flag_d;
  logic wake_q;
  logic wake_d;

  // Set takes priority over the write-one-to-clear strobe
  always_comb begin
    flag_d = flag_q;
    if (set_req) begin
      flag_d = 1'b1;
    end else if (clr_req) begin
      flag_d = 1'b0;
    end
    wake_d = set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      wake_q <= wake_d;
    end
  end

  assign flag = flag_q;
  assign wake = wake_q;

  // R7: a set is never lost, even against a clear
  assert_set_wins_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    set_req |=> flag_q
  );

  // R7: the flag holds until it is cleared
  assert_flag_sticky_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q
  );

  // R8: the wake pulse lasts one cycle
  assert_wake_single_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q
  );

endmodule

// File: rtl/watch_timer.sv
module watch_timer
  import wt_pkg::*;
#(
  parameter int unsigned MAIN_DIV = 128,
  parameter int unsigned DIV_W    = 14,
  parameter int unsigned FAST_W   = 7,
  parameter int unsigned BUZ_BIT  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       flag_clr,
  input  logic       buz_dir_out,
  output logic       tick_flag,
  output logic       wake,
  output logic       buz_pin
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // Mode register
  wt_mode_t mode_q;
  wt_mode_t mode_d;
  logic     restart;
  logic     unused_mode_bits;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) begin
      mode_d.src_sub = mode_wdata[MODE_SRC_BIT];
      mode_d.fast    = mode_wdata[MODE_FAST_BIT];
      mode_d.run     = mode_wdata[MODE_RUN_BIT];
      mode_d.buz_en  = mode_wdata[MODE_BUZ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign restart          = mode_we && mode_wdata[MODE_CLR_BIT];
  assign unused_mode_bits = ^mode_wdata[6:4];

  logic ref_tick;
  logic set_req;
  logic buz_tap;

  wt_refsel #(
    .MAIN_DIV (MAIN_DIV)
  ) u_refsel (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (mode_q.run),
    .restart  (restart),
    .src_sub  (mode_q.src_sub),
    .sub_tick (sub_tick),
    .ref_tick (ref_tick)
  );

  wt_divider #(
    .DIV_W   (DIV_W),
    .FAST_W  (FAST_W),
    .BUZ_BIT (BUZ_BIT)
  ) u_divider (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (mode_q.run),
    .restart  (restart),
    .fast     (mode_q.fast),
    .ref_tick (ref_tick),
    .set_req  (set_req),
    .buz_tap  (buz_tap)
  );

  wt_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_req (set_req),
    .clr_req (flag_clr),
    .flag    (tick_flag),
    .wake    (wake)
  );

  // Buzzer gate: enable bit and port direction
  assign buz_pin = mode_q.buz_en && buz_dir_out && buz_tap;

  // R5: one cycle after run is low, the buzzer is silent
  assert_buz_idle_stopped_R5: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    !mode_q.run |=> !buz_pin
  );

  // R8: a wake pulse comes with the flag set
  assert_wake_with_flag_R8: assert property (
    @(posedge clk) disable iff (!rst_int_n)
    wake |-> tick_flag
  );

endmodule

// File: tb/sim_watch_timer.sv
module sim_watch_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 8;

  // Vector fields: mode byte, edges to wait after the start write, expected flag
  localparam logic [24:0] VECS [0:NVEC-1] = '{
    {8'h07, 16'd127,   1'b0},  // R3 fast, subsystem
    {8'h07, 16'd128,   1'b1},  // R3
    {8'h05, 16'd16383, 1'b0},  // R2 normal, subsystem
    {8'h05, 16'd16384, 1'b1},  // R2
    {8'h06, 16'd16383, 1'b0},  // R4 fast, main prescaled
    {8'h06, 16'd16384, 1'b1},  // R4
    {8'h77, 16'd127,   1'b0},  // R10 bits 4..6 set
    {8'h77, 16'd128,   1'b1}   // R10
  };

  logic       clk;
  logic       rst_n;
  logic       sub_tick;
  logic       mode_we;
  logic [7:0] mode_wdata;
  logic       flag_clr;
  logic       buz_dir_out;
  logic       tick_flag;
  logic       wake;
  logic       buz_pin;

  int n_checks;
  int n_fails;

  watch_timer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .sub_tick    (sub_tick),
    .mode_we     (mode_we),
    .mode_wdata  (mode_wdata),
    .flag_clr    (flag_clr),
    .buz_dir_out (buz_dir_out),
    .tick_flag   (tick_flag),
    .wake        (wake),
    .buz_pin     (buz_pin)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Write the mode register; return just after the write edge
  task automatic wr_mode(input logic [7:0] d);
    @(negedge clk);
    mode_we    = 1'b1;
    mode_wdata = d;
    @(posedge clk);
    #1;
    mode_we    = 1'b0;
    mode_wdata = 8'h00;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(posedge clk);
    #1;
    flag_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fails++;
    $display("FAIL watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    string req;
    n_checks    = 0;
    n_fails     = 0;
    rst_n       = 1'b0;
    sub_tick    = 1'b1;
    mode_we     = 1'b0;
    mode_wdata  = 8'h00;
    flag_clr    = 1'b0;
    buz_dir_out = 1'b1;

    // R1 reset state
    repeat (4) @(posedge clk);
    #1;
    check("R1", "flag in reset", tick_flag, 1'b0);
    check("R1", "wake in reset", wake, 1'b0);
    check("R1", "buzzer in reset", buz_pin, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    edges(5);
    check("R1", "flag after reset", tick_flag, 1'b0);
    check("R1", "buzzer after reset", buz_pin, 1'b0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      wr_mode(8'h00);
      clear_flag();
      wr_mode(VECS[i][24:17]);
      edges(int'(VECS[i][16:1]));
      if (i < 2)      req = "R3";
      else if (i < 4) req = "R2";
      else if (i < 6) req = "R4";
      else            req = "R10";
      check(req, $sformatf("vector %0d flag", i), tick_flag, VECS[i][0]);
    end

    // R8 wake pulse and R7 stickiness / clear
    wr_mode(8'h00);
    clear_flag();
    wr_mode(8'h07);
    edges(128);
    check("R8", "wake with flag set", wake, 1'b1);
    check("R8", "flag with wake", tick_flag, 1'b1);
    edges(1);
    check("R8", "wake after one cycle", wake, 1'b0);
    check("R7", "flag held", tick_flag, 1'b1);
    clear_flag();
    check("R7", "flag cleared", tick_flag, 1'b0);

    // R7 set and clear on the same edge
    wr_mode(8'h00);
    clear_flag();
    wr_mode(8'h07);
    edges(127);
    check("R7", "flag before collision", tick_flag, 1'b0);
    clear_flag();
    check("R7", "set beats clear", tick_flag, 1'b1);
    clear_flag();
    check("R7", "later clear works", tick_flag, 1'b0);

    // R6 divider clear mid-period, acting once only
    wr_mode(8'h00);
    clear_flag();
    wr_mode(8'h07);
    edges(100);
    wr_mode(8'h0F);
    edges(127);
    check("R6", "no flag before restarted period", tick_flag, 1'b0);
    edges(1);
    check("R6", "flag after restarted period", tick_flag, 1'b1);
    clear_flag();
    edges(127);
    check("R6", "next period full length", tick_flag, 1'b1);

    // R5 stopped timer
    wr_mode(8'h00);
    clear_flag();
    wr_mode(8'h81);
    edges(20000);
    check("R5", "no flag while stopped", tick_flag, 1'b0);
    check("R5", "buzzer low while stopped", buz_pin, 1'b0);

    // R9 buzzer tap and gating
    wr_mode(8'h00);
    clear_flag();
    wr_mode(8'h85);
    edges(7);
    check("R9", "count 7", buz_pin, 1'b0);
    edges(1);
    check("R9", "count 8", buz_pin, 1'b1);
    edges(7);
    check("R9", "count 15", buz_pin, 1'b1);
    edges(1);
    check("R9", "count 16", buz_pin, 1'b0);
    edges(8);
    check("R9", "count 24", buz_pin, 1'b1);
    @(negedge clk);
    buz_dir_out = 1'b0;
    #1;
    check("R9", "port as input", buz_pin, 1'b0);
    @(negedge clk);
    buz_dir_out = 1'b1;
    #1;
    check("R9", "port as output", buz_pin, 1'b1);
    wr_mode(8'h05);
    check("R9", "buzzer disabled", buz_pin, 1'b0);

    finish_run();
  end

endmodule